// File: doc/BRIEF.md
# Configurable Port Pin Controller

This block controls one 8-bit quasi-bidirectional I/O port in which every pin picks its own output type. It holds the port's output data latch and two configuration registers. The same bit position in the two registers selects that pin's output mode. The block does not model the analog drivers. For each pin it produces three enables: a pull-down, a strong pull-up and a weak pull-up. It also returns the pin levels, after a synchroniser, as read data.

An alternative peripheral function can take over a pin's output value, but only while that pin's latch bit holds a 1. In quasi-bidirectional mode, a low-to-high change of a pin's output fires the strong pull-up for one clock. That pulse sets a per-pin hold latch, and the hold latch keeps the weak pull-up on for as long as the output stays high. Pins marked as two-wire bus pins can only be open-drain or high-impedance. Reset values of the latch and of both configuration registers are parameters.

Top module: `port_pin_ctrl`

## Requirements
- R1: Pin i's mode is {cfg_b[i], cfg_a[i]}: 2'b00 open-drain, 2'b01 quasi-bidirectional, 2'b10 high-impedance, 2'b11 push-pull. A write with wr_en_i=1 and wr_sel_i 0, 1 or 2 loads wr_data_i into the data latch, config A or config B respectively.
- R2: Open-drain pin: pull_dn_o equals the inverted output value, and both pull-up enables stay 0.
- R3: Quasi pin: one clock after the output value goes 0 to 1, str_up_o is 1 for exactly one clock. weak_up_o is then 1 while the output stays 1 and drops as soon as the output is 0. A latch rewrite that leaves the bit at 1 fires no pulse.
- R4: High-impedance pin: all three driver enables are 0.
- R5: Push-pull pin: str_up_o equals the output value and pull_dn_o equals its inverse, with no delay after the register update.
- R6: A pin's output value is latch & (alt_out_i if alt_en_i else 1). An alternative function can drive the pin only while the latch bit is 1.
- R7: On bus pins (BUS_MASK, default bits 7 and 6), config A is ignored. cfg_b=1 gives high-impedance and cfg_b=0 gives open-drain, so these pins never enable a pull-up.
- R8: After reset, the data latch, config A and config B hold RST_DATA (0x7F), RST_CFG_A (0x08) and RST_CFG_B (0x7F). No strong pulse follows reset.
- R9: pin_o shows pin_i after SYNC_STAGES (2) clock edges.
- R10: A write with wr_sel_i=3 changes no register.
- R11: On a pin, pull_dn_o is never 1 together with str_up_o or with weak_up_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 latch, 1 config A, 2 config B, 3 none |
| wr_data_i | input | 8 | Write data |
| alt_en_i | input | 8 | Per-pin alternative function active |
| alt_out_i | input | 8 | Per-pin alternative function output value |
| pin_i | input | 8 | Raw pin levels |
| pin_o | output | 8 | Synchronised pin levels |
| pull_dn_o | output | 8 | Pull-down enables |
| str_up_o | output | 8 | Strong pull-up enables |
| weak_up_o | output | 8 | Weak pull-up enables |

## Verification
The assertions check four things on every clock. The pull-down never coexists with either pull-up. Bus pins and high-impedance pins never enable a pull-up. A quasi pin's strong pull-up never lasts two clocks in a row. The pin read path lags the input by the synchroniser depth. The directed scenarios cover the rest: the mode encoding, the exact clock in which the strong pulse appears, the hold of the weak pull-up and its release, the gating of alternative functions by the latch, the forcing of bus pins, the ignored select code and the reset values. Each of these depends on a particular sequence of register writes.

// File: rtl/port_pkg.sv
package port_pkg;
  typedef enum logic [1:0] {
    MODE_OD    = 2'b00,
    MODE_QUASI = 2'b01,
    MODE_HIZ   = 2'b10,
    MODE_PP    = 2'b11
  } pin_mode_e;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CFGA = 2'd1;
  localparam logic [1:0] SEL_CFGB = 2'd2;
endpackage

// File: rtl/port_regs.sv
module port_regs import port_pkg::*; #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] RST_DATA = '1,
  parameter logic [WIDTH-1:0] RST_CFG_A = '1,
  parameter logic [WIDTH-1:0] RST_CFG_B = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] data_q_o,
  output logic [WIDTH-1:0] cfg_a_o,
  output logic [WIDTH-1:0] cfg_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= RST_DATA;
      cfg_a_o  <= RST_CFG_A;
      cfg_b_o  <= RST_CFG_B;
    end else if (wr_en_i) begin
      // select code 3 falls through: no register written
      case (wr_sel_i)
        SEL_DATA: data_q_o <= wr_data_i;
        SEL_CFGA: cfg_a_o  <= wr_data_i;
        SEL_CFGB: cfg_b_o  <= wr_data_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/port_pin_sync.sv
module port_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/port_pin_drv.sv
module port_pin_drv import port_pkg::*; #(
  parameter bit IS_BUS  = 1'b0,
  parameter bit RST_OUT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_i,
  input  logic cfg_a_i,
  input  logic cfg_b_i,
  input  logic alt_en_i,
  input  logic alt_out_i,
  output logic pull_dn_o,
  output logic str_up_o,
  output logic weak_up_o,
  output logic quasi_o,
  output logic hiz_o
);
  pin_mode_e mode;
  logic      out_val;
  logic      out_q, pulse_q, hold_q;

  generate
    if (IS_BUS) begin : g_bus
      assign mode = cfg_b_i ? MODE_HIZ : MODE_OD;
    end else begin : g_std
      assign mode = pin_mode_e'({cfg_b_i, cfg_a_i});
    end
  endgenerate

  // alternative function only passes while the latch bit is 1
  assign out_val = latch_i & (~alt_en_i | alt_out_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= RST_OUT;
      pulse_q <= 1'b0;
      hold_q  <= RST_OUT;
    end else begin
      out_q   <= out_val;
      pulse_q <= out_val & ~out_q;
      hold_q  <= out_val & (hold_q | pulse_q);
    end
  end

  always_comb begin
    pull_dn_o = 1'b0;
    str_up_o  = 1'b0;
    weak_up_o = 1'b0;
    unique case (mode)
      MODE_OD: pull_dn_o = ~out_val;
      MODE_QUASI: begin
        pull_dn_o = ~out_val;
        str_up_o  = out_val & pulse_q;
        weak_up_o = out_val & (hold_q | pulse_q);
      end
      MODE_HIZ: ;
      MODE_PP: begin
        pull_dn_o = ~out_val;
        str_up_o  = out_val;
      end
      default: ;
    endcase
  end

  assign quasi_o = (mode == MODE_QUASI);
  assign hiz_o   = (mode == MODE_HIZ);
endmodule

// File: rtl/port_pin_ctrl.sv
module port_pin_ctrl #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] RST_DATA  = 8'h7F,
  parameter logic [WIDTH-1:0] RST_CFG_A = 8'h08,
  parameter logic [WIDTH-1:0] RST_CFG_B = 8'h7F,
  parameter logic [WIDTH-1:0] BUS_MASK  = 8'hC0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] alt_en_i,
  input  logic [WIDTH-1:0] alt_out_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pull_dn_o,
  output logic [WIDTH-1:0] str_up_o,
  output logic [WIDTH-1:0] weak_up_o
);
  logic [WIDTH-1:0] data_q, cfg_a, cfg_b;
  logic [WIDTH-1:0] quasi_mask, hiz_mask;

  port_regs #(
    .WIDTH(WIDTH), .RST_DATA(RST_DATA), .RST_CFG_A(RST_CFG_A), .RST_CFG_B(RST_CFG_B)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .data_q_o(data_q), .cfg_a_o(cfg_a), .cfg_b_o(cfg_b)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    port_pin_drv #(.IS_BUS(BUS_MASK[i]), .RST_OUT(RST_DATA[i])) u_drv (
      .clk_i(clk_i), .rst_ni(rst_ni), .latch_i(data_q[i]),
      .cfg_a_i(cfg_a[i]), .cfg_b_i(cfg_b[i]),
      .alt_en_i(alt_en_i[i]), .alt_out_i(alt_out_i[i]),
      .pull_dn_o(pull_dn_o[i]), .str_up_o(str_up_o[i]), .weak_up_o(weak_up_o[i]),
      .quasi_o(quasi_mask[i]), .hiz_o(hiz_mask[i])
    );
  end

  port_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_o)
  );
endmodule

// File: rtl/port_pin_chk.sv
module port_pin_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] BUS_MASK = 8'hC0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pull_dn_o,
  input logic [WIDTH-1:0] str_up_o,
  input logic [WIDTH-1:0] weak_up_o,
  input logic [WIDTH-1:0] quasi_mask,
  input logic [WIDTH-1:0] hiz_mask
);
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assert_no_contention_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pull_dn_o & (str_up_o | weak_up_o)) == '0));

  assert_bus_no_pullup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((str_up_o | weak_up_o) & BUS_MASK) == '0));

  assert_hiz_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pull_dn_o | str_up_o | weak_up_o) & hiz_mask) == '0));

  assert_quasi_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((str_up_o & quasi_mask & $past(str_up_o & quasi_mask)) == '0));

  generate
    if (STAGES == 2) begin : g_sync2
      assert_sync_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst >= 3'd4) |-> (pin_o == $past(pin_i, 2)));
    end
  endgenerate
endmodule

bind port_pin_ctrl port_pin_chk #(
  .WIDTH(WIDTH), .STAGES(SYNC_STAGES), .BUS_MASK(BUS_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .pin_o(pin_o),
  .pull_dn_o(pull_dn_o), .str_up_o(str_up_o), .weak_up_o(weak_up_o),
  .quasi_mask(quasi_mask), .hiz_mask(hiz_mask)
);

// File: tb/sim_port_pin_ctrl.sv
`timescale 1ns/100ps
module sim_port_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] alt_en = 8'h00;
  logic [7:0] alt_out = 8'h00;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_rd, pd, su, wu;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  port_pin_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .alt_en_i(alt_en), .alt_out_i(alt_out),
    .pin_i(pin_in), .pin_o(pin_rd), .pull_dn_o(pd), .str_up_o(su), .weak_up_o(wu)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic chk3(input string req, input logic [7:0] e_pd, input logic [7:0] e_su,
                      input logic [7:0] e_wu);
    chk(req, "pull_dn", pd, e_pd);
    chk(req, "str_up", su, e_su);
    chk(req, "weak_up", wu, e_wu);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    // R8: pins 0-2,4,5 hi-Z; pin3 push-pull high; pin6 bus hi-Z; pin7 bus OD low
    chk3("R8", 8'h80, 8'h08, 8'h00);
  endtask

  task automatic t_open_drain();
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h55);
    chk3("R2", 8'hAA, 8'h00, 8'h00);
    step();
    chk3("R2", 8'hAA, 8'h00, 8'h00);
  endtask

  task automatic t_push_pull();
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h0F);
    // R1/R5 on pins 0-5; R7: bus pins 6,7 forced hi-Z by cfg_b=1
    chk3("R5", 8'h30, 8'h0F, 8'h00);
    wr(2'd0, 8'h3C);
    chk3("R5", 8'h03, 8'h3C, 8'h00);
  endtask

  task automatic t_hiz();
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd0, 8'h00);
    chk3("R4", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_quasi();
    wr(2'd1, 8'hFF); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    step(); step();
    // R7: bus pins with cfg_a=1 act open-drain
    chk3("R3", 8'hFF, 8'h00, 8'h00);
    wr(2'd0, 8'h3C);
    chk3("R3", 8'hC3, 8'h00, 8'h00);
    step();
    chk3("R3", 8'hC3, 8'h3C, 8'h3C);
    step();
    chk3("R3", 8'hC3, 8'h00, 8'h3C);
    step();
    chk3("R3", 8'hC3, 8'h00, 8'h3C);
    wr(2'd0, 8'h30);
    chk3("R3", 8'hCF, 8'h00, 8'h30);
    wr(2'd0, 8'h30);
    step();
    chk3("R3", 8'hCF, 8'h00, 8'h30);
    wr(2'd0, 8'hB0);
    step();
    chk3("R7", 8'h4F, 8'h00, 8'h30);
  endtask

  task automatic t_alt();
    wr(2'd0, 8'h3F);
    step(); step();
    @(negedge clk);
    alt_en = 8'h01; alt_out = 8'h00;
    #0.1;
    chk("R6", "pull_dn alt low", pd, 8'hC1);
    step();
    alt_out = 8'h01;
    #0.1;
    chk("R6", "str_up before pulse", su, 8'h00);
    step();
    chk("R6", "str_up alt rise", su, 8'h01);
    step();
    chk("R6", "str_up alt after", su, 8'h00);
    wr(2'd0, 8'h3E);
    chk("R6", "latch gates alt", pd, 8'hC1);
    @(negedge clk);
    alt_en = 8'h00; alt_out = 8'h00;
  endtask

  task automatic t_sel3();
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h0F);
    wr(2'd3, 8'hF0);
    step();
    chk3("R10", 8'hF0, 8'h00, 8'h00);
    chk3("R1", 8'hF0, 8'h00, 8'h00);
  endtask

  task automatic t_sync();
    @(negedge clk);
    pin_in = 8'hA5;
    step();
    chk("R9", "pin_o after 1 edge", pin_rd, 8'h00);
    step();
    chk("R9", "pin_o after 2 edges", pin_rd, 8'hA5);
    pin_in = 8'h3C;
    step(); step();
    chk("R9", "pin_o second value", pin_rd, 8'h3C);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(); step();
    t_reset();
    t_open_drain();
    t_push_pull();
    t_hiz();
    t_quasi();
    t_alt();
    t_sel3();
    t_sync();
    finish_run();
  end
endmodule